// File: doc/BRIEF.md
# Puzzle Memory Load, Check and Restore Sequencer

This block owns the two grid memories of a 9x9 number-puzzle game: a solution memory that holds the full answer, and a game memory that holds what the player sees. It runs four operations, each started by a one-cycle command strobe:

- **Load** brings a fresh puzzle in from a read-only store.
- **Check** compares the player's grid against the answer.
- **Restore** puts back only the given clues.
- **Reveal** copies the whole answer onto the grid.

The read-only store is split into three difficulty pages, each holding a fixed number of puzzles of 81 bytes. A free-running picker decides which puzzle of the requested page is taken when a load arrives. In every stored byte, bit 0 marks a given (starting) cell, and bits 7..1 carry the cell's display value.

The grid memories are addressed with a packed cell address. The column number sits in the upper nibble and the row number in the lower nibble. The sequencer walks a linear puzzle offset and produces the matching packed address alongside it.

All three memories are assumed to return read data one clock after the address is presented. While any operation runs, the grid display is blanked, and a one-cycle done pulse marks the end. A check leaves its verdict on two indicator outputs.

Top module: `pz_mem_sequencer`

## Requirements
- R1: While reset is held, and after it is released with no command given, grid_blank, done, ok_led, bad_led, sol_we and gam_we are all low.
- R2: Commands are taken only while idle, and strobes that arrive during an operation have no effect. When several strobes arrive together, the priority is load, then restore, then reveal, then check.
- R3: Puzzle selection works as follows:
  - The page is the level input, except that level 3 selects page 2.
  - A load starts at ROM address 81*(N + page*GAMES_PER_PAGE).
  - N advances by one on every clock and wraps from GAMES_PER_PAGE-1 to 0.
  - Two loads accepted d clocks apart therefore use indices that differ by d modulo GAMES_PER_PAGE.
- R4: A load reads the 81 consecutive ROM bytes of the selected puzzle. Offset k goes to packed cell address {k/9, k%9}, with the column in bits 7..4 and the row in bits 3..0. Every byte is written unchanged into the solution memory.
- R5: During a load, each game memory cell receives the ROM byte if its bit 0 is set, and 8'h00 otherwise.
- R6: A check compares all 81 cell pairs on bits 7..1 only.
  - At the end, ok_led goes high if every pair matches; otherwise bad_led goes high.
  - The two indicators are never high together.
  - Both are cleared when any operation starts, and they hold their value at all other times.
- R7: A restore leaves every game memory cell equal to the solution byte where that byte's bit 0 is set, and 8'h00 elsewhere, whatever the cell held before.
- R8: A reveal leaves every game memory cell equal to its solution memory byte.
- R9: grid_blank rises on the clock edge that accepts a command and stays high for exactly 82 cycles. done is high for exactly one cycle, in the first cycle after grid_blank falls.
- R10: Neither memory write enable is ever high while grid_blank is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Strobe: load a new puzzle |
| cmd_check | input | 1 | Strobe: check the player's grid |
| cmd_reset | input | 1 | Strobe: restore starting values |
| cmd_giveup | input | 1 | Strobe: reveal the full answer |
| level | input | 2 | Difficulty page select |
| rom_addr | output | 10 | Puzzle store read address |
| rom_rdata | input | 8 | Puzzle store read data (one-cycle latency) |
| sol_raddr | output | 8 | Solution memory packed read address |
| sol_rdata | input | 8 | Solution memory read data |
| sol_waddr | output | 8 | Solution memory packed write address |
| sol_wdata | output | 8 | Solution memory write data |
| sol_we | output | 1 | Solution memory write enable |
| gam_raddr | output | 8 | Game memory packed read address |
| gam_rdata | input | 8 | Game memory read data |
| gam_waddr | output | 8 | Game memory packed write address |
| gam_wdata | output | 8 | Game memory write data |
| gam_we | output | 1 | Game memory write enable |
| grid_blank | output | 1 | Display blank, high while an operation runs |
| done | output | 1 | One-cycle end-of-operation pulse |
| ok_led | output | 1 | Check verdict: grid correct |
| bad_led | output | 1 | Check verdict: grid wrong |

## Verification
The checker watches the cycle-level contract on every clock:

- writes occur only while blanked;
- written cells stay inside the 9x9 grid;
- the ROM address stays inside the store;
- the blank window never exceeds its length;
- done is a single pulse that follows the fall of blank;
- the two indicators are exclusive, and they hold between operations.

What lands in the memories can only be shown by the bench scenarios, which inspect the memory models after each operation:

- the clue masking on load and restore;
- the full copy on reveal;
- the masked comparison and its verdict.

The same holds for the picker's stride and page arithmetic, the command priority, and the rejection of strobes during a run.

// File: rtl/pz_pkg.sv
`timescale 1ns/1ps
package pz_pkg;

  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_CHECK   = 2'd1,
    OP_RESTORE = 2'd2,
    OP_REVEAL  = 2'd3
  } pz_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_DRAIN = 2'd2
  } pz_st_e;

  typedef struct packed {
    logic load;
    logic check;
    logic restore;
    logic reveal;
  } pz_cmd_t;

endpackage

// File: rtl/pz_game_picker.sv
`timescale 1ns/1ps
// Free-running puzzle selector: strides by one puzzle size inside a page,
// and adds the page base chosen by the difficulty level.
module pz_game_picker #(
  parameter int GAME_BYTES     = 81,
  parameter int GAMES_PER_PAGE = 4,
  parameter int PAGES          = 3,
  parameter int LVL_W          = 2,
  parameter int ROM_AW         = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  level,
  output logic [ROM_AW-1:0] start_addr
);

  localparam int                PAGE_BYTES = GAME_BYTES * GAMES_PER_PAGE;
  localparam logic [ROM_AW-1:0] LAST_OFF   = ROM_AW'((GAMES_PER_PAGE - 1) * GAME_BYTES);
  localparam logic [ROM_AW-1:0] STRIDE     = ROM_AW'(GAME_BYTES);

  logic [ROM_AW-1:0] off_q, off_d;
  logic [ROM_AW-1:0] page_base;

  always_comb begin
    if (off_q == LAST_OFF) off_d = '0;
    else                   off_d = off_q + STRIDE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end

  // Levels beyond the last page fall onto the last page.
  always_comb begin
    page_base = ROM_AW'((PAGES - 1) * PAGE_BYTES);
    for (int p = 0; p < PAGES - 1; p++) begin
      if (int'(level) == p) page_base = ROM_AW'(p * PAGE_BYTES);
    end
  end

  assign start_addr = page_base + off_q;

endmodule

// File: rtl/pz_cell_walker.sv
`timescale 1ns/1ps
// Walks the linear puzzle offset and keeps the packed column/row pair
// in step with it, so no divider is needed.
module pz_cell_walker #(
  parameter int GRID  = 9,
  parameter int POS_W = 4,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic [POS_W-1:0] col,
  output logic [POS_W-1:0] row,
  output logic             last
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GRID * GRID - 1);
  localparam logic [POS_W-1:0] ROW_LAST = POS_W'(GRID - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [POS_W-1:0] col_q, col_d, row_q, row_d;
  logic             en;

  assign en = start | step;

  always_comb begin
    idx_d = idx_q;
    col_d = col_q;
    row_d = row_q;
    if (start) begin
      idx_d = '0;
      col_d = '0;
      row_d = '0;
    end else if (step) begin
      idx_d = idx_q + 1'b1;
      if (row_q == ROW_LAST) begin
        row_d = '0;
        col_d = col_q + 1'b1;
      end else begin
        row_d = row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (en) begin
      idx_q <= idx_d;
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign idx  = idx_q;
  assign col  = col_q;
  assign row  = row_q;
  assign last = (idx_q == IDX_LAST);

endmodule

// File: rtl/pz_xfer_path.sv
`timescale 1ns/1ps
// Write and compare datapath for the cell that returned from memory
// this cycle.
module pz_xfer_path
  import pz_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CELL_AW = 8
) (
  input  pz_op_e              op,
  input  logic                p_valid,
  input  logic [CELL_AW-1:0]  p_addr,
  input  logic [DATA_W-1:0]   rom_rdata,
  input  logic [DATA_W-1:0]   sol_rdata,
  input  logic [DATA_W-1:0]   gam_rdata,
  output logic                sol_we,
  output logic [CELL_AW-1:0]  sol_waddr,
  output logic [DATA_W-1:0]   sol_wdata,
  output logic                gam_we,
  output logic [CELL_AW-1:0]  gam_waddr,
  output logic [DATA_W-1:0]   gam_wdata,
  output logic                mismatch
);

  localparam logic [DATA_W-1:0] BLANK    = '0;
  localparam logic [DATA_W-1:0] VAL_MASK = {{(DATA_W-1){1'b1}}, 1'b0};

  always_comb begin
    sol_we    = 1'b0;
    gam_we    = 1'b0;
    sol_wdata = rom_rdata;
    gam_wdata = BLANK;
    mismatch  = 1'b0;
    case (op)
      OP_LOAD: begin
        sol_we    = p_valid;
        gam_we    = p_valid;
        gam_wdata = rom_rdata[0] ? rom_rdata : BLANK;
      end
      OP_RESTORE: begin
        gam_we    = p_valid;
        gam_wdata = sol_rdata[0] ? sol_rdata : BLANK;
      end
      OP_REVEAL: begin
        gam_we    = p_valid;
        gam_wdata = sol_rdata;
      end
      OP_CHECK: begin
        mismatch = p_valid && ((sol_rdata & VAL_MASK) != (gam_rdata & VAL_MASK));
      end
      default: ;
    endcase
  end

  assign sol_waddr = p_addr;
  assign gam_waddr = p_addr;

endmodule

// File: rtl/pz_mem_sequencer.sv
`timescale 1ns/1ps
module pz_mem_sequencer
  import pz_pkg::*;
#(
  parameter int    GRID           = 9,
  parameter int    GAMES_PER_PAGE = 4,
  parameter int    PAGES          = 3,
  parameter int    DATA_W         = 8,
  parameter int    LVL_W          = 2,
  localparam int   GAME_BYTES     = GRID * GRID,
  localparam int   POS_W          = $clog2(GRID),
  localparam int   CELL_AW        = 2 * POS_W,
  localparam int   IDX_W          = $clog2(GAME_BYTES),
  localparam int   ROM_DEPTH      = PAGES * GAMES_PER_PAGE * GAME_BYTES,
  localparam int   ROM_AW         = $clog2(ROM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_load,
  input  logic               cmd_check,
  input  logic               cmd_reset,
  input  logic               cmd_giveup,
  input  logic [LVL_W-1:0]   level,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [DATA_W-1:0]  rom_rdata,
  output logic [CELL_AW-1:0] sol_raddr,
  input  logic [DATA_W-1:0]  sol_rdata,
  output logic [CELL_AW-1:0] sol_waddr,
  output logic [DATA_W-1:0]  sol_wdata,
  output logic               sol_we,
  output logic [CELL_AW-1:0] gam_raddr,
  input  logic [DATA_W-1:0]  gam_rdata,
  output logic [CELL_AW-1:0] gam_waddr,
  output logic [DATA_W-1:0]  gam_wdata,
  output logic               gam_we,
  output logic               grid_blank,
  output logic               done,
  output logic               ok_led,
  output logic               bad_led
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // Command decode with fixed priority.
  pz_cmd_t cmd;
  pz_op_e  op_sel;
  logic    cmd_any;

  assign cmd     = '{load: cmd_load, check: cmd_check, restore: cmd_reset, reveal: cmd_giveup};
  assign cmd_any = cmd.load | cmd.check | cmd.restore | cmd.reveal;

  always_comb begin
    if (cmd.load)         op_sel = OP_LOAD;
    else if (cmd.restore) op_sel = OP_RESTORE;
    else if (cmd.reveal)  op_sel = OP_REVEAL;
    else                  op_sel = OP_CHECK;
  end

  // Sub-blocks
  logic [ROM_AW-1:0] pick_addr;
  logic [IDX_W-1:0]  w_idx;
  logic [POS_W-1:0]  w_col, w_row;
  logic              w_last, w_start, w_step;
  logic              mismatch;

  pz_st_e            st_q, st_d;
  pz_op_e            op_q, op_d;
  logic [ROM_AW-1:0] base_q, base_d;
  logic              pv_q, pv_d;
  logic [CELL_AW-1:0] pa_q, pa_d;
  logic              acc_q, acc_d;
  logic              ok_q, ok_d;
  logic              bad_q, bad_d;
  logic              done_q, done_d;
  logic              accept;

  pz_game_picker #(
    .GAME_BYTES    (GAME_BYTES),
    .GAMES_PER_PAGE(GAMES_PER_PAGE),
    .PAGES         (PAGES),
    .LVL_W         (LVL_W),
    .ROM_AW        (ROM_AW)
  ) u_picker (
    .clk       (clk),
    .rst_n     (rst_sn),
    .level     (level),
    .start_addr(pick_addr)
  );

  pz_cell_walker #(
    .GRID (GRID),
    .POS_W(POS_W),
    .IDX_W(IDX_W)
  ) u_walker (
    .clk  (clk),
    .rst_n(rst_sn),
    .start(w_start),
    .step (w_step),
    .idx  (w_idx),
    .col  (w_col),
    .row  (w_row),
    .last (w_last)
  );

  pz_xfer_path #(
    .DATA_W (DATA_W),
    .CELL_AW(CELL_AW)
  ) u_xfer (
    .op       (op_q),
    .p_valid  (pv_q),
    .p_addr   (pa_q),
    .rom_rdata(rom_rdata),
    .sol_rdata(sol_rdata),
    .gam_rdata(gam_rdata),
    .sol_we   (sol_we),
    .sol_waddr(sol_waddr),
    .sol_wdata(sol_wdata),
    .gam_we   (gam_we),
    .gam_waddr(gam_waddr),
    .gam_wdata(gam_wdata),
    .mismatch (mismatch)
  );

  // Next-state logic
  assign accept  = (st_q == ST_IDLE) && cmd_any;
  assign w_start = accept;
  assign w_step  = (st_q == ST_WALK) && !w_last;

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    base_d = base_q;
    acc_d  = acc_q;
    ok_d   = ok_q;
    bad_d  = bad_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_WALK;
          op_d   = op_sel;
          base_d = pick_addr;
          acc_d  = 1'b0;
          ok_d   = 1'b0;
          bad_d  = 1'b0;
        end
      end
      ST_WALK: begin
        if (w_last)   st_d  = ST_DRAIN;
        if (mismatch) acc_d = 1'b1;
      end
      ST_DRAIN: begin
        st_d = ST_IDLE;
        if (op_q == OP_CHECK) begin
          ok_d  = !(acc_q | mismatch);
          bad_d = acc_q | mismatch;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // The read pipeline stage: marks the cycle in which memory data returns.
  assign pv_d   = (st_q == ST_WALK);
  assign pa_d   = {w_col, w_row};
  assign done_d = (st_q == ST_DRAIN);

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_CHECK;
      base_q <= '0;
      pv_q   <= 1'b0;
      pa_q   <= '0;
      acc_q  <= 1'b0;
      ok_q   <= 1'b0;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      if (accept) begin
        op_q   <= op_d;
        base_q <= base_d;
      end
      pv_q   <= pv_d;
      pa_q   <= pa_d;
      acc_q  <= acc_d;
      ok_q   <= ok_d;
      bad_q  <= bad_d;
      done_q <= done_d;
    end
  end

  // Outputs
  assign rom_addr   = base_q + ROM_AW'(w_idx);
  assign sol_raddr  = {w_col, w_row};
  assign gam_raddr  = {w_col, w_row};
  assign grid_blank = (st_q != ST_IDLE);
  assign done       = done_q;
  assign ok_led     = ok_q;
  assign bad_led    = bad_q;

endmodule

// File: rtl/pz_mem_sequencer_chk.sv
`timescale 1ns/1ps
module pz_mem_sequencer_chk #(
  parameter int GRID      = 9,
  parameter int POS_W     = 4,
  parameter int CELL_AW   = 8,
  parameter int ROM_AW    = 10,
  parameter int ROM_DEPTH = 972
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ROM_AW-1:0]  rom_addr,
  input logic               sol_we,
  input logic               gam_we,
  input logic [CELL_AW-1:0] gam_waddr,
  input logic               grid_blank,
  input logic               done,
  input logic               ok_led,
  input logic               bad_led
);

  localparam int RUN_MAX = GRID * GRID + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 2) + 1;

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (grid_blank) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  AST_ROM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, rom_addr} < (ROM_AW+1)'(ROM_DEPTH)); // R3

  AST_WRITE_ONLY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (sol_we || gam_we) |-> grid_blank); // R10

  AST_CELL_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    gam_we |-> (gam_waddr[POS_W-1:0] < POS_W'(GRID)) &&
               (gam_waddr[CELL_AW-1:POS_W] < POS_W'(GRID))); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_ENDS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!grid_blank && $past(grid_blank))); // R9

  AST_BLANK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RUN_W'(RUN_MAX)); // R9

  AST_LED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_led && bad_led)); // R6

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!grid_blank && !done) |-> ($stable(ok_led) && $stable(bad_led))); // R6

endmodule

bind pz_mem_sequencer pz_mem_sequencer_chk #(
  .GRID     (GRID),
  .POS_W    (POS_W),
  .CELL_AW  (CELL_AW),
  .ROM_AW   (ROM_AW),
  .ROM_DEPTH(ROM_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rom_addr  (rom_addr),
  .sol_we    (sol_we),
  .gam_we    (gam_we),
  .gam_waddr (gam_waddr),
  .grid_blank(grid_blank),
  .done      (done),
  .ok_led    (ok_led),
  .bad_led   (bad_led)
);

// File: tb/pz_mem_sequencer_tb.sv
`timescale 1ns/1ps
module pz_mem_sequencer_tb;

  localparam int L      = 81;
  localparam int NTOT   = 4;
  localparam int PG     = 3;
  localparam int RDEPTH = PG * NTOT * L;

  logic       clk, rst_n;
  logic       cmd_load, cmd_check, cmd_reset, cmd_giveup;
  logic [1:0] level;
  logic [9:0] rom_addr;
  logic [7:0] rom_rd, sol_rd, gam_rd;
  logic [7:0] sol_raddr, sol_waddr, sol_wdata, gam_raddr, gam_waddr, gam_wdata;
  logic       sol_we, gam_we, grid_blank, done, ok_led, bad_led;

  logic [7:0] sol_m [256];
  logic [7:0] gam_m [256];
  logic [7:0] sol_snap [256];
  logic       poke_we;
  logic [7:0] poke_addr, poke_data;

  int n_chk, n_bad, cyc;

  pz_mem_sequencer u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_load(cmd_load), .cmd_check(cmd_check), .cmd_reset(cmd_reset), .cmd_giveup(cmd_giveup),
    .level(level),
    .rom_addr(rom_addr), .rom_rdata(rom_rd),
    .sol_raddr(sol_raddr), .sol_rdata(sol_rd), .sol_waddr(sol_waddr), .sol_wdata(sol_wdata), .sol_we(sol_we),
    .gam_raddr(gam_raddr), .gam_rdata(gam_rd), .gam_waddr(gam_waddr), .gam_wdata(gam_wdata), .gam_we(gam_we),
    .grid_blank(grid_blank), .done(done), .ok_led(ok_led), .bad_led(bad_led)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(input int a);
    logic [7:0] r;
    r    = 8'((a * 29 + 7) % 251);
    r[0] = ((a * 13) % 4) == 0;
    return r;
  endfunction

  function automatic logic [7:0] cell_addr(input int k);
    return 8'(((k / 9) << 4) | (k % 9));
  endfunction

  // Memory models: one-cycle read latency
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    rom_rd <= rom_byte(int'(rom_addr));
    sol_rd <= sol_m[sol_raddr];
    gam_rd <= gam_m[gam_raddr];
    if (sol_we) sol_m[sol_waddr] <= sol_wdata;
    if (gam_we) gam_m[gam_waddr] <= gam_wdata;
    else if (poke_we) gam_m[poke_addr] <= poke_data;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke_we = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_we = 1'b0;
  endtask

  // which: bit0 load, bit1 check, bit2 restore, bit3 reveal
  task automatic run_cmd(input logic [3:0] which, input logic [1:0] lvl, input bit noise,
                         output int base, output int t0);
    int cnt;
    bit saw_done;
    @(negedge clk);
    cmd_load = which[0]; cmd_check = which[1]; cmd_reset = which[2]; cmd_giveup = which[3];
    level = lvl;
    t0 = cyc;
    @(negedge clk);
    cmd_load = 0; cmd_check = 0; cmd_reset = 0; cmd_giveup = 0;
    base = int'(rom_addr);
    cnt = 0; saw_done = 0;
    while (grid_blank && cnt < 1000) begin
      if (done) saw_done = 1;
      cnt++;
      if (noise && cnt == 10) begin
        cmd_load = 1; cmd_check = 1; level = 2'd2;
      end else if (noise && cnt == 11) begin
        cmd_load = 0; cmd_check = 0;
      end
      @(negedge clk);
    end
    chk(cnt == L + 1, "R9", "blank length", cnt, L + 1);
    chk(done && !saw_done, "R9", "done at blank fall", int'(done), 1);
    @(negedge clk);
    chk(!done, "R9", "done width", int'(done), 0);
  endtask

  task automatic check_load(input int base, input logic [1:0] lvl, input string req);
    int page, es, eg;
    logic [7:0] b, eb;
    page = (lvl > 2) ? 2 : int'(lvl);
    chk(base % L == 0, "R3", "start on puzzle boundary", base % L, 0);
    chk(base / (NTOT * L) == page, req, "page of start", base / (NTOT * L), page);
    es = 0; eg = 0;
    for (int k = 0; k < L; k++) begin
      b  = rom_byte(base + k);
      eb = b[0] ? b : 8'h00;
      if (sol_m[cell_addr(k)] !== b) begin
        if (es == 0) $display("FAIL R4 sol cell %0d: actual=%0d expected=%0d", k, sol_m[cell_addr(k)], b);
        es++;
      end
      if (gam_m[cell_addr(k)] !== eb) begin
        if (eg == 0) $display("FAIL R5 game cell %0d: actual=%0d expected=%0d", k, gam_m[cell_addr(k)], eb);
        eg++;
      end
    end
    n_chk += 2;
    if (es != 0) n_bad++;
    if (eg != 0) n_bad++;
  endtask

  function automatic bit grids_match();
    bit m;
    m = 1;
    for (int k = 0; k < L; k++)
      if ((sol_m[cell_addr(k)] & 8'hFE) !== (gam_m[cell_addr(k)] & 8'hFE)) m = 0;
    return m;
  endfunction

  task automatic do_check(input string what);
    int b, t;
    bit exp;
    exp = grids_match();
    run_cmd(4'b0010, 2'd0, 0, b, t);
    chk(ok_led == exp, "R6", {what, " ok_led"}, int'(ok_led), int'(exp));
    chk(bad_led == !exp, "R6", {what, " bad_led"}, int'(bad_led), int'(!exp));
  endtask

  task automatic expect_game(input bit full, input string req);
    int e;
    logic [7:0] s, x;
    e = 0;
    for (int k = 0; k < L; k++) begin
      s = sol_m[cell_addr(k)];
      x = (full || s[0]) ? s : 8'h00;
      if (gam_m[cell_addr(k)] !== x) begin
        if (e == 0) $display("FAIL %s game cell %0d: actual=%0d expected=%0d", req, k, gam_m[cell_addr(k)], x);
        e++;
      end
    end
    n_chk++;
    if (e != 0) n_bad++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base, t0, pn, pt, n, e;
    n_chk = 0; n_bad = 0; cyc = 0;
    rst_n = 0; cmd_load = 0; cmd_check = 0; cmd_reset = 0; cmd_giveup = 0;
    level = 0; poke_we = 0; poke_addr = 0; poke_data = 0;
    repeat (4) @(negedge clk);
    chk(!grid_blank && !done && !ok_led && !bad_led, "R1", "outputs in reset",
        int'({grid_blank, done, ok_led, bad_led}), 0);
    chk(!sol_we && !gam_we, "R1", "write enables in reset", int'({sol_we, gam_we}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!grid_blank && !done && !ok_led && !bad_led && !sol_we && !gam_we, "R1",
        "outputs after release", int'({grid_blank, done, ok_led, bad_led}), 0);

    // Sweep all levels and selection phases
    pn = -1; pt = 0;
    for (int lv = 0; lv < 4; lv++) begin
      for (int rep = 0; rep < NTOT; rep++) begin
        repeat (rep + lv) @(negedge clk);
        run_cmd(4'b0001, 2'(lv), 0, base, t0);
        check_load(base, 2'(lv), "R3");
        n = (base / L) % NTOT;
        if (pn >= 0) chk(n == (pn + (t0 - pt)) % NTOT, "R3", "index stride", n, (pn + (t0 - pt)) % NTOT);
        pn = n; pt = t0;
      end
    end

    // Check with only clues present, then reveal and check again
    do_check("clues only");
    repeat (20) @(negedge clk);
    chk(bad_led && !ok_led, "R6", "verdict hold", int'(bad_led), 1);
    for (int k = 0; k < 256; k++) sol_snap[k] = sol_m[k];
    run_cmd(4'b1000, 2'd0, 1, base, t0);
    expect_game(1, "R8");
    chk(!ok_led && !bad_led, "R6", "indicators cleared at start", int'({ok_led, bad_led}), 0);
    e = 0;
    for (int k = 0; k < 256; k++) if (sol_snap[k] !== sol_m[k]) e++;
    chk(e == 0, "R2", "busy strobes left solution", e, 0);
    repeat (20) begin
      @(negedge clk);
      chk(!grid_blank, "R2", "no run from busy strobes", int'(grid_blank), 0);
    end
    do_check("after reveal");

    // Masked comparison
    poke(cell_addr(L - 1), gam_m[cell_addr(L - 1)] ^ 8'h01);
    do_check("marker bit differs");
    poke(cell_addr(0), gam_m[cell_addr(0)] ^ 8'h10);
    do_check("first cell differs");
    poke(cell_addr(0), gam_m[cell_addr(0)] ^ 8'h10);
    poke(cell_addr(L - 1), gam_m[cell_addr(L - 1)] ^ 8'h80);
    do_check("last cell differs");

    // Restore over a fully written grid
    run_cmd(4'b0100, 2'd0, 0, base, t0);
    expect_game(0, "R7");
    do_check("after restore");

    // Priority: restore beats reveal and check
    run_cmd(4'b1110, 2'd0, 0, base, t0);
    expect_game(0, "R2");
    chk(!ok_led && !bad_led, "R2", "check lost priority", int'({ok_led, bad_led}), 0);
    // Priority: load beats everything
    run_cmd(4'b1111, 2'd1, 0, base, t0);
    check_load(base, 2'd1, "R2");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule